// File: doc/BRIEF.md
# Disk Slot LED State Tracker

The host never writes disk LED states directly. It sends one-shot commands instead: it writes a slot number to a command register, and each register means either "turn on" or "turn off" for one LED function. This block watches a plain register write bus made of address, write enable and data. It keeps one bit per slot for each of four functions: present, error, locate and activity. The four masks are output continuously, so front-panel or status logic can read the current picture at any time.

Each function has a pair of adjacent addresses: the "on" register first and the "off" register next. The pairs sit in a fixed order above a base address. A slot number too large for the masks is dropped without effect. The block only holds state. Blink patterns and LED drive belong to later logic.

Top module: `disk_led_tracker`

## Requirements
- R1: While `rst_n` is low, all four masks are forced to zero, and they stay zero after reset releases until a command arrives.
- R2: Command addresses are fixed. Function f (0 = present, 1 = error, 2 = locate, 3 = active) has its "on" register at 0x15A + 2f and its "off" register at 0x15A + 2f + 1, so the "on" registers are 0x15A, 0x15C, 0x15E and 0x160. All 16 address bits are decoded.
- R3: A write to an "on" register with a data byte below 32 sets the bit numbered by that byte in the mask of that function. The change is visible on the outputs after the next rising clock edge.
- R4: A write to an "off" register with a data byte below 32 clears the bit numbered by that byte in the mask of that function. It has the same one-edge latency as R3.
- R5: A command write whose data byte is 32 to 255 (0x20..0xFF) changes no mask.
- R6: A write to any address outside 0x15A..0x161, and any cycle with `wr_en` low (whatever the address and data), leaves all masks unchanged.
- R7: An accepted command changes only the addressed bit of the addressed mask. All other bits and all other masks hold.
- R8: Setting a bit that is already set, or clearing a bit that is already clear, leaves the masks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 8 | Write data, used as a slot number |
| present_mask | output | 32 | Per-slot present state |
| error_mask | output | 32 | Per-slot error state |
| locate_mask | output | 32 | Per-slot locate state |
| active_mask | output | 32 | Per-slot activity state |

## Verification
The assertions check the following on every cycle:
- an accepted "on" or "off" command lands on the right bit of the right function one edge later;
- out-of-range slot numbers, foreign addresses and idle cycles leave all four masks stable;
- no cycle ever flips more than one bit across the whole set of masks.

Some behaviours can only be shown by the bench's command sequences:
- the absolute address map, including the base value and the decoding of the high address bits;
- state that builds up over many commands, such as both edge slots 0 and 31 being set together;
- repeated commands that change nothing;
- a reset arriving after the masks hold data.

// File: rtl/disk_led_tracker.sv
module disk_led_tracker #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int SLOTS     = 32,
  parameter int BASE_ADDR = 'h15A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SLOTS-1:0]  present_mask,
  output logic [SLOTS-1:0]  error_mask,
  output logic [SLOTS-1:0]  locate_mask,
  output logic [SLOTS-1:0]  active_mask
);
  localparam int NFUNC = 4;
  localparam int IDX_W = $clog2(SLOTS);
  localparam logic [DATA_W-1:0] SLOTS_D = DATA_W'(SLOTS);

  logic             idx_ok;
  logic [IDX_W-1:0] idx;
  logic [NFUNC-1:0][SLOTS-1:0] mask_q;

  assign idx_ok = wr_en && (wr_data < SLOTS_D);
  assign idx    = wr_data[IDX_W-1:0];

  for (genvar f = 0; f < NFUNC; f++) begin : g_func
    localparam logic [ADDR_W-1:0] ON_A  = ADDR_W'(BASE_ADDR + 2*f);
    localparam logic [ADDR_W-1:0] OFF_A = ADDR_W'(BASE_ADDR + 2*f + 1);
    logic set_cmd, clr_cmd;
    logic [SLOTS-1:0] bits_q;

    assign set_cmd = idx_ok && (wr_addr == ON_A);
    assign clr_cmd = idx_ok && (wr_addr == OFF_A);

    always_ff @(posedge clk) begin
      if (!rst_n)       bits_q      <= '0;
      else if (set_cmd) bits_q[idx] <= 1'b1;
      else if (clr_cmd) bits_q[idx] <= 1'b0;
    end

    assign mask_q[f] = bits_q;
  end

  assign present_mask = mask_q[0];
  assign error_mask   = mask_q[1];
  assign locate_mask  = mask_q[2];
  assign active_mask  = mask_q[3];
endmodule

// File: rtl/disk_led_tracker_chk.sv
module disk_led_tracker_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int SLOTS     = 32,
  parameter int BASE_ADDR = 'h15A
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [SLOTS-1:0]  present_mask,
  input logic [SLOTS-1:0]  error_mask,
  input logic [SLOTS-1:0]  locate_mask,
  input logic [SLOTS-1:0]  active_mask
);
  localparam int IDX_W = $clog2(SLOTS);
  localparam logic [DATA_W-1:0] SLOTS_D = DATA_W'(SLOTS);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE_ADDR + 7);

  logic [4*SLOTS-1:0] all_m;
  logic in_win;
  assign all_m  = {active_mask, locate_mask, error_mask, present_mask};
  assign in_win = (wr_addr >= LO_A) && (wr_addr <= HI_A);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (all_m == '0));

  p_big_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data >= SLOTS_D) |=> $stable(all_m));

  p_foreign_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || !in_win) |=> $stable(all_m));

  p_single_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($countones(all_m ^ $past(all_m)) <= 1));

  for (genvar f = 0; f < 4; f++) begin : g_f
    localparam logic [ADDR_W-1:0] ON_A  = ADDR_W'(BASE_ADDR + 2*f);
    localparam logic [ADDR_W-1:0] OFF_A = ADDR_W'(BASE_ADDR + 2*f + 1);
    logic [SLOTS-1:0] m;
    assign m = all_m[f*SLOTS +: SLOTS];

    p_on_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ON_A && wr_data < SLOTS_D)
        |=> m[$past(wr_data[IDX_W-1:0])]);

    p_off_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == OFF_A && wr_data < SLOTS_D)
        |=> !m[$past(wr_data[IDX_W-1:0])]);
  end
endmodule

bind disk_led_tracker disk_led_tracker_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS), .BASE_ADDR(BASE_ADDR)
) u_chk (.*);

// File: tb/sim_disk_led_tracker.sv
`timescale 1ns/1ps
module sim_disk_led_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [31:0] present_mask, error_mask, locate_mask, active_mask;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  disk_led_tracker u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .present_mask(present_mask), .error_mask(error_mask),
    .locate_mask(locate_mask), .active_mask(active_mask)
  );

  // {req, addr, data, present, error, locate, active}
  localparam int NV = 17;
  localparam logic [155:0] VEC [NV] = '{
    {4'd3, 16'h015A, 8'h00, 32'h0000_0001, 32'h0, 32'h0, 32'h0},
    {4'd3, 16'h015A, 8'h1F, 32'h8000_0001, 32'h0, 32'h0, 32'h0},
    {4'd2, 16'h015C, 8'h05, 32'h8000_0001, 32'h0000_0020, 32'h0, 32'h0},
    {4'd2, 16'h015E, 8'h1F, 32'h8000_0001, 32'h0000_0020, 32'h8000_0000, 32'h0},
    {4'd2, 16'h0160, 8'h03, 32'h8000_0001, 32'h0000_0020, 32'h8000_0000, 32'h8},
    {4'd4, 16'h015B, 8'h00, 32'h8000_0000, 32'h0000_0020, 32'h8000_0000, 32'h8},
    {4'd5, 16'h015A, 8'h20, 32'h8000_0000, 32'h0000_0020, 32'h8000_0000, 32'h8},
    {4'd5, 16'h015C, 8'hFF, 32'h8000_0000, 32'h0000_0020, 32'h8000_0000, 32'h8},
    {4'd6, 16'h0159, 8'h01, 32'h8000_0000, 32'h0000_0020, 32'h8000_0000, 32'h8},
    {4'd6, 16'h0162, 8'h01, 32'h8000_0000, 32'h0000_0020, 32'h8000_0000, 32'h8},
    {4'd4, 16'h015D, 8'h05, 32'h8000_0000, 32'h0, 32'h8000_0000, 32'h8},
    {4'd8, 16'h015D, 8'h05, 32'h8000_0000, 32'h0, 32'h8000_0000, 32'h8},
    {4'd4, 16'h0161, 8'h03, 32'h8000_0000, 32'h0, 32'h8000_0000, 32'h0},
    {4'd7, 16'h015F, 8'h1F, 32'h8000_0000, 32'h0, 32'h0, 32'h0},
    {4'd7, 16'h015E, 8'h0A, 32'h8000_0000, 32'h0, 32'h0000_0400, 32'h0},
    {4'd8, 16'h015A, 8'h1F, 32'h8000_0000, 32'h0, 32'h0000_0400, 32'h0},
    {4'd6, 16'h115A, 8'h01, 32'h8000_0000, 32'h0, 32'h0000_0400, 32'h0}
  };

  function automatic string tag(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [127:0] exp);
    logic [127:0] act;
    act = {present_mask, error_mask, locate_mask, active_mask};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write(input logic en, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 128'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", 128'h0);

    for (int i = 0; i < NV; i++) begin
      write(1'b1, VEC[i][151:136], VEC[i][135:128]);
      check(tag(VEC[i][155:152]), VEC[i][127:0]);
    end

    // R6: strobe low on a valid command address
    write(1'b0, 16'h015A, 8'h02);
    check("R6", {32'h8000_0000, 32'h0, 32'h0000_0400, 32'h0});
    write(1'b0, 16'h015F, 8'h0A);
    check("R6", {32'h8000_0000, 32'h0, 32'h0000_0400, 32'h0});

    // R3 / R7: error and active edge slots
    write(1'b1, 16'h015C, 8'h1F);
    write(1'b1, 16'h0160, 8'h00);
    check("R7", {32'h8000_0000, 32'h8000_0000, 32'h0000_0400, 32'h0000_0001});

    // R1: reset with populated state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1", 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 128'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule